// File: doc/BRIEF.md
# Priority Region Memory Protection Unit

This block maps a 32-bit access address to memory attributes: memory type, cache policy, shareability and an execute-never flag. A build holds 0, 8 or 12 programmable regions. Each region has a base address, a power-of-two size, an enable bit and a 6-bit attribute word. Regions may overlap. Among the enabled regions that contain the address, the one with the highest index decides the result. If no enabled region contains the address, or if the global enable is off, a fixed built-in memory map supplies the attributes and the hit flag stays low. The built-in map depends on the top address nibble, on whether the access is an instruction fetch, on the two cache enables and on a high-vectors input.

Regions are programmed through a register port of address, write enable and write data, with a combinational read-data return. The port works only while the privileged input is high and only in builds that have at least one region. The lookup path is fully combinational: a new address produces its attributes in the same cycle, and a register write affects lookups from the cycle after the write edge. No interface on this block carries a data stream, so every pin is a plain level signal and none applies back-pressure.

Top module: `region_guard`

## Requirements
- R1: After reset every region is disabled and the global enable is 0. Lookups then return the built-in map with `hit` low, and the global-enable register reads 0.
- R2: Built-in map, top nibble 0xF: `xn` equals the inverse of `hivecs`. A fetch with `hivecs` high is Normal (mem_type 2), non-cacheable (cache_pol 0) and non-shared. Every other access in this range is Strongly Ordered (mem_type 0), non-cacheable and shared.
- R3: Built-in map, nibbles 0x8 to 0xE, all with `xn` high: 0xC–0xE is Strongly Ordered and shared, 0xA–0xB is Device (mem_type 1) and shared, 0x8–0x9 is Device and non-shared. cache_pol is 0 in all of them.
- R4: Built-in map, nibbles 0x0 to 0x7, fetches: Normal, non-shared, `xn` low, and cache_pol 2 (write-back write-allocate) when `icache_en` is high, otherwise 0.
- R5: Built-in map, nibbles 0x0 to 0x7, data accesses with `dcache_en` high: Normal with `xn` low. 0x0–0x3 is cache_pol 2 and non-shared, 0x4–0x5 is cache_pol 1 (write-through) and non-shared, 0x6–0x7 is cache_pol 0 and shared.
- R6: Built-in map, nibbles 0x0 to 0x7, data accesses with `dcache_en` low: Normal, cache_pol 0, shared, `xn` low.
- R7: A region with size code N covers 2^(N+1) bytes, and codes below 4 are treated as 4 (32 bytes). Its base is aligned down to the size. Code 31 covers the whole address space.
- R8: When enabled regions overlap, the region with the highest index that contains the address supplies the outputs, and `hit` is high. The outputs are the stored attribute bits: bit 5 `xn`, bit 4 `shared`, bits 3:2 `cache_pol`, bits 1:0 `mem_type`.
- R9: While the global enable is 0, or when no enabled region contains the address, the outputs follow the built-in map and `hit` is low.
- R10: With `priv` low, writes change no register and `cfg_rdata` reads 0.
- R11: A build with NUM_RGN = 0 ignores every write, reads 0 at every address, and always outputs the built-in map with `hit` low.
- R12: Register map. `cfg_addr[5:2]` selects the region and `cfg_addr[1:0]` selects the field. Field 0 holds the base in data[31:5]. Field 1 holds the size code in data[5:1] and the enable in data[0]. Field 2 holds the attribute in data[5:0]. Field 3 reads 0. Address 0x3F holds the global enable in data[0]. Unimplemented bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| priv | input | 1 | Privileged mode; enables register access |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register address (region index, field) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| acc_addr | input | 32 | Address being looked up |
| acc_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| icache_en | input | 1 | Instruction cache enabled |
| dcache_en | input | 1 | Data cache enabled |
| hivecs | input | 1 | High exception vectors selected |
| mem_type | output | 2 | 0 Strongly Ordered, 1 Device, 2 Normal |
| cache_pol | output | 2 | 0 non-cacheable, 1 write-through, 2 write-back write-allocate |
| shared | output | 1 | Shareable |
| xn | output | 1 | Execute-never |
| hit | output | 1 | An enabled region decided the result |

## Verification
The hardest case to reach from the ports is a three-way overlap. A higher-index region must sit fully inside a lower one, the address must lie just inside or just outside the smaller region's aligned edge, and a size code below the 32-byte floor must be in play at the same time. Directed sequences build nested regions with unaligned bases and probe both edges. Random programming then places lookup addresses next to programmed bases, with small offsets and flipped low bits, so that random traffic repeatedly crosses region edges. A zero-region instance shares every input and is compared against the built-in map throughout.

// File: rtl/rgn_pkg.sv
package rgn_pkg;
  localparam int AW     = 32;
  localparam int MIN_LG = 5;
  localparam int SZ_W   = 5;
  localparam int IDX_W  = 4;
  localparam int FLD_W  = 2;
  localparam int CA_W   = IDX_W + FLD_W;
  localparam logic [SZ_W-1:0] SZ_FLOOR = 5'd4;
  localparam logic [CA_W-1:0] GLB_ADDR = '1;

  typedef enum logic [1:0] {MT_SO = 2'd0, MT_DEV = 2'd1, MT_NORM = 2'd2} mtype_e;
  typedef enum logic [1:0] {CP_NC = 2'd0, CP_WT = 2'd1, CP_WB = 2'd2} cpol_e;

  typedef struct packed {
    logic   xn;
    logic   shared;
    cpol_e  cpol;
    mtype_e mtype;
  } attr_t;

  typedef struct packed {
    logic [AW-1:MIN_LG] base;
    logic [SZ_W-1:0]    size;
    logic               en;
    attr_t              attr;
  } rgn_t;
endpackage

// File: rtl/rgn_regs.sv
module rgn_regs
  import rgn_pkg::*;
#(
  parameter int NUM_RGN = 12,
  parameter int NSLOT   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  priv,
  input  logic                  we,
  input  logic [CA_W-1:0]       addr,
  input  logic [AW-1:0]         wdata,
  output logic [AW-1:0]         rdata,
  output logic                  glb_en,
  output rgn_t [NSLOT-1:0]      rgn
);
  localparam bit HAS = (NUM_RGN > 0);

  logic             wr_ok;
  logic [IDX_W-1:0] idx;
  logic [FLD_W-1:0] fld;
  rgn_t             regs_q [NSLOT];

  assign wr_ok = we && priv && HAS;
  assign idx   = addr[CA_W-1:FLD_W];
  assign fld   = addr[FLD_W-1:0];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (wr_ok && (g < NUM_RGN) && idx == IDX_W'(g) && addr != GLB_ADDR) begin
        case (fld)
          2'd0: regs_q[g].base <= wdata[AW-1:MIN_LG];
          2'd1: {regs_q[g].size, regs_q[g].en} <= wdata[SZ_W:0];
          2'd2: regs_q[g].attr <= attr_t'(wdata[5:0]);
          default: ;
        endcase
      end
    end
    assign rgn[g] = regs_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          glb_en <= 1'b0;
    else if (wr_ok && addr == GLB_ADDR)  glb_en <= wdata[0];
  end

  always_comb begin
    rdata = '0;
    if (priv && HAS) begin
      if (addr == GLB_ADDR) begin
        rdata[0] = glb_en;
      end else begin
        for (int i = 0; i < NUM_RGN; i++) begin
          if (idx == IDX_W'(i)) begin
            case (fld)
              2'd0: rdata = {regs_q[i].base, {MIN_LG{1'b0}}};
              2'd1: rdata[SZ_W:0] = {regs_q[i].size, regs_q[i].en};
              2'd2: rdata[5:0] = regs_q[i].attr;
              default: rdata = '0;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/rgn_match.sv
module rgn_match
  import rgn_pkg::*;
(
  input  rgn_t          r,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [SZ_W-1:0] lg;
  logic [5:0]      sh;
  logic [AW-1:0]   keep;

  always_comb begin
    lg   = (r.size < SZ_FLOOR) ? SZ_FLOOR : r.size;
    sh   = {1'b0, lg} + 6'd1;
    keep = ~((AW'(1) << sh) - AW'(1));
    hit  = r.en && (((addr ^ {r.base, {MIN_LG{1'b0}}}) & keep) == '0);
  end
endmodule

// File: rtl/dflt_map.sv
module dflt_map
  import rgn_pkg::*;
(
  input  logic [3:0] nib,
  input  logic       fetch,
  input  logic       ic_en,
  input  logic       dc_en,
  input  logic       hv,
  output attr_t      a
);
  always_comb begin
    a.xn     = nib[3];
    a.shared = 1'b1;
    a.cpol   = CP_NC;
    a.mtype  = MT_SO;
    unique case (nib[3:1])
      3'b111: begin
        if (nib[0]) begin
          a.xn = !hv;
          if (fetch && hv) begin
            a.mtype  = MT_NORM;
            a.shared = 1'b0;
          end
        end
      end
      3'b110: ;
      3'b101: a.mtype = MT_DEV;
      3'b100: begin
        a.mtype  = MT_DEV;
        a.shared = 1'b0;
      end
      default: begin
        a.mtype = MT_NORM;
        if (fetch) begin
          a.shared = 1'b0;
          a.cpol   = ic_en ? CP_WB : CP_NC;
        end else if (dc_en && !nib[2]) begin
          a.shared = 1'b0;
          a.cpol   = CP_WB;
        end else if (dc_en && nib[2:1] == 2'b10) begin
          a.shared = 1'b0;
          a.cpol   = CP_WT;
        end
      end
    endcase
  end
endmodule

// File: rtl/region_guard.sv
module region_guard
  import rgn_pkg::*;
#(
  parameter int NUM_RGN = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        priv,
  input  logic        cfg_we,
  input  logic [5:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [31:0] acc_addr,
  input  logic        acc_fetch,
  input  logic        icache_en,
  input  logic        dcache_en,
  input  logic        hivecs,
  output logic [1:0]  mem_type,
  output logic [1:0]  cache_pol,
  output logic        shared,
  output logic        xn,
  output logic        hit
);
  localparam int NSLOT = (NUM_RGN == 0) ? 1 : NUM_RGN;
  localparam bit HAS   = (NUM_RGN > 0);

  logic             glb_en;
  rgn_t [NSLOT-1:0] rgn;
  logic [NSLOT-1:0] hits;
  attr_t            dattr;
  attr_t            sel;

  rgn_regs #(.NUM_RGN(NUM_RGN), .NSLOT(NSLOT)) u_regs (
    .clk(clk), .rst_n(rst_n), .priv(priv), .we(cfg_we),
    .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .glb_en(glb_en), .rgn(rgn)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_match
    rgn_match u_m (.r(rgn[g]), .addr(acc_addr), .hit(hits[g]));
  end

  dflt_map u_dflt (
    .nib(acc_addr[31:28]), .fetch(acc_fetch), .ic_en(icache_en),
    .dc_en(dcache_en), .hv(hivecs), .a(dattr)
  );

  always_comb begin
    sel = dattr;
    hit = 1'b0;
    if (glb_en && HAS) begin
      for (int i = 0; i < NSLOT; i++) begin
        if (hits[i]) begin
          sel = rgn[i].attr;
          hit = 1'b1;
        end
      end
    end
  end

  assign mem_type  = sel.mtype;
  assign cache_pol = sel.cpol;
  assign shared    = sel.shared;
  assign xn        = sel.xn;
endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        priv,
  input logic        cfg_we,
  input logic [31:0] cfg_rdata,
  input logic [31:0] acc_addr,
  input logic        acc_fetch,
  input logic        icache_en,
  input logic        dcache_en,
  input logic        hivecs,
  input logic [1:0]  mem_type,
  input logic [1:0]  cache_pol,
  input logic        shared,
  input logic        xn,
  input logic        hit,
  input logic        glb_en
);
  // R9
  glb_off_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !hit);

  // R10
  unpriv_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !priv |-> cfg_rdata == 32'd0);

  // R10
  unpriv_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !priv) |=> $stable(glb_en));

  // R2
  top_nib_xn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && acc_addr[31:28] == 4'hF) |-> (xn == !hivecs));

  // R3
  dev_so_xn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && acc_addr[31] && acc_addr[31:28] != 4'hF) |-> (xn && mem_type != 2'd2 && cache_pol == 2'd0));

  // R4
  fetch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && acc_fetch && !acc_addr[31]) |->
      (!xn && !shared && mem_type == 2'd2 && cache_pol == (icache_en ? 2'd2 : 2'd0)));

  // R6
  data_nocache_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !acc_fetch && !dcache_en && !acc_addr[31]) |->
      (mem_type == 2'd2 && cache_pol == 2'd0 && shared && !xn));
endmodule

bind region_guard region_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .priv(priv), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
  .acc_addr(acc_addr), .acc_fetch(acc_fetch), .icache_en(icache_en),
  .dcache_en(dcache_en), .hivecs(hivecs), .mem_type(mem_type),
  .cache_pol(cache_pol), .shared(shared), .xn(xn), .hit(hit), .glb_en(glb_en)
);

// File: tb/region_guard_test.sv
module region_guard_test;
  localparam int NR = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic priv = 1'b1, cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, acc_addr = '0;
  logic acc_fetch = 1'b0, icache_en = 1'b0, dcache_en = 1'b0, hivecs = 1'b0;
  logic [31:0] cfg_rdata, z_rdata;
  logic [1:0]  mem_type, cache_pol, z_mt, z_cp;
  logic        shared, xn, hit, z_sh, z_xn, z_hit;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [26:0] m_base [NR];
  logic [4:0]  m_size [NR];
  logic        m_en   [NR];
  logic [5:0]  m_attr [NR];
  logic        m_glb;

  always #2 clk = ~clk;

  region_guard #(.NUM_RGN(NR)) uut (
    .clk(clk), .rst_n(rst_n), .priv(priv), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
    .acc_fetch(acc_fetch), .icache_en(icache_en), .dcache_en(dcache_en),
    .hivecs(hivecs), .mem_type(mem_type), .cache_pol(cache_pol),
    .shared(shared), .xn(xn), .hit(hit));

  region_guard #(.NUM_RGN(0)) uut_z (
    .clk(clk), .rst_n(rst_n), .priv(priv), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(z_rdata), .acc_addr(acc_addr),
    .acc_fetch(acc_fetch), .icache_en(icache_en), .dcache_en(dcache_en),
    .hivecs(hivecs), .mem_type(z_mt), .cache_pol(z_cp),
    .shared(z_sh), .xn(z_xn), .hit(z_hit));

  // Packed result: {hit, xn, shared, cache_pol[1:0], mem_type[1:0]}
  function automatic logic [5:0] dmap(logic [3:0] t, bit f, bit ic, bit dc, bit hv);
    if (t == 4'hF)      return (f && hv) ? 6'b0_0_00_10 : {!hv, 5'b1_00_00};
    else if (t >= 4'hC) return 6'b1_1_00_00;
    else if (t >= 4'hA) return 6'b1_1_00_01;
    else if (t >= 4'h8) return 6'b1_0_00_01;
    else if (f)         return ic ? 6'b0_0_10_10 : 6'b0_0_00_10;
    else if (!dc)       return 6'b0_1_00_10;
    else if (t < 4'h4)  return 6'b0_0_10_10;
    else if (t < 4'h6)  return 6'b0_0_01_10;
    else                return 6'b0_1_00_10;
  endfunction

  function automatic logic [6:0] mlook(logic [31:0] a, bit f, bit ic, bit dc, bit hv);
    logic [6:0] r;
    r = {1'b0, dmap(a[31:28], f, ic, dc, hv)};
    if (m_glb) begin
      for (int i = 0; i < NR; i++) begin
        if (m_en[i]) begin
          int sz;
          logic [63:0] span, lo;
          sz   = (m_size[i] < 5'd4) ? 4 : int'(m_size[i]);
          span = 64'd1 << (sz + 1);
          lo   = {32'd0, m_base[i], 5'd0} & ~(span - 64'd1);
          if ({32'd0, a} >= lo && {32'd0, a} < lo + span) r = {1'b1, m_attr[i]};
        end
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] mread(logic [5:0] a, bit p);
    if (!p) return 32'd0;
    if (a == 6'h3F) return {31'd0, m_glb};
    if (a[5:2] >= NR) return 32'd0;
    case (a[1:0])
      2'd0: return {m_base[a[5:2]], 5'd0};
      2'd1: return {26'd0, m_size[a[5:2]], m_en[a[5:2]]};
      2'd2: return {26'd0, m_attr[a[5:2]]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d, bit p);
    @(negedge clk);
    priv = p; cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; priv = 1'b1;
    if (p) begin
      if (a == 6'h3F) m_glb = d[0];
      else if (a[5:2] < NR) begin
        case (a[1:0])
          2'd0: m_base[a[5:2]] = d[31:5];
          2'd1: {m_size[a[5:2]], m_en[a[5:2]]} = d[5:0];
          2'd2: m_attr[a[5:2]] = d[5:0];
          default: ;
        endcase
      end
    end
  endtask

  task automatic rd(logic [5:0] a, bit p, string req);
    priv = p; cfg_addr = a;
    #1;
    chk(cfg_rdata == mread(a, p), req, cfg_rdata, mread(a, p));
    chk(z_rdata == 32'd0, "R11", z_rdata, 32'd0);
    priv = 1'b1;
  endtask

  task automatic look(logic [31:0] a, bit f, bit ic, bit dc, bit hv, string req);
    logic [6:0] e, act, zact, ze;
    acc_addr = a; acc_fetch = f; icache_en = ic; dcache_en = dc; hivecs = hv;
    #1;
    e    = mlook(a, f, ic, dc, hv);
    act  = {hit, xn, shared, cache_pol, mem_type};
    chk(act == e, req, {25'd0, act}, {25'd0, e});
    ze   = {1'b0, dmap(a[31:28], f, ic, dc, hv)};
    zact = {z_hit, z_xn, z_sh, z_cp, z_mt};
    chk(zact == ze, "R11", {25'd0, zact}, {25'd0, ze});
  endtask

  function automatic string req_of(logic [3:0] t, bit f, bit dc);
    if (t == 4'hF) return "R2";
    if (t[3])      return "R3";
    if (f)         return "R4";
    return dc ? "R5" : "R6";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    m_glb = 1'b0;
    for (int i = 0; i < NR; i++) begin
      m_base[i] = '0; m_size[i] = '0; m_en[i] = 1'b0; m_attr[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(6'h3F, 1'b1, "R1");
    rd(6'h01, 1'b1, "R1");
    look(32'h0000_1234, 1'b0, 1'b1, 1'b1, 1'b0, "R1");
    chk(hit == 1'b0, "R1", {31'd0, hit}, 32'd0);

    // R2..R6: built-in map sweep with global enable off
    for (int t = 0; t < 16; t++)
      for (int c = 0; c < 16; c++)
        look({t[3:0], 28'h0ABCDE0} ^ {4'h0, c[3:0], 24'h0}, c[0], c[1], c[2], c[3],
             req_of(t[3:0], c[0], c[2]));

    // R9: region enabled but global enable off
    wr(6'h00, 32'h3000_0000, 1'b1);
    wr(6'h01, {26'd0, 5'd10, 1'b1}, 1'b1);
    wr(6'h02, 32'h0000_002E, 1'b1);
    look(32'h3000_0010, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    chk(hit == 1'b0, "R9", {31'd0, hit}, 32'd0);

    // R10: unprivileged writes ignored, reads zero
    wr(6'h3F, 32'h1, 1'b0);
    look(32'h3000_0010, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
    chk(hit == 1'b0, "R10", {31'd0, hit}, 32'd0);
    wr(6'h00, 32'h5000_0000, 1'b0);
    rd(6'h00, 1'b1, "R10");
    rd(6'h00, 1'b0, "R10");
    rd(6'h3F, 1'b0, "R10");

    // R12: readback layout
    wr(6'h3F, 32'hFFFF_FFFF, 1'b1);
    rd(6'h3F, 1'b1, "R12");
    rd(6'h00, 1'b1, "R12");
    rd(6'h01, 1'b1, "R12");
    rd(6'h02, 1'b1, "R12");
    rd(6'h03, 1'b1, "R12");
    rd(6'h34, 1'b1, "R12");

    // R7: size floor and alignment
    wr(6'h00, 32'h1000_0071, 1'b1);
    wr(6'h01, {26'd0, 5'd2, 1'b1}, 1'b1);
    look(32'h1000_0060, 1'b0, 1'b1, 1'b1, 1'b0, "R7");
    chk(hit == 1'b1, "R7", {31'd0, hit}, 32'd1);
    look(32'h1000_007F, 1'b0, 1'b1, 1'b1, 1'b0, "R7");
    look(32'h1000_005F, 1'b0, 1'b1, 1'b1, 1'b0, "R7");
    chk(hit == 1'b0, "R7", {31'd0, hit}, 32'd0);
    look(32'h1000_0080, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
    wr(6'h01, {26'd0, 5'd6, 1'b1}, 1'b1);
    look(32'h1000_0000, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    look(32'h1000_007F, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    look(32'h1000_0080, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    wr(6'h01, {26'd0, 5'd31, 1'b1}, 1'b1);
    look(32'hFFFF_FFF0, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
    chk(hit == 1'b1, "R7", {31'd0, hit}, 32'd1);

    // R8: overlap priority
    wr(6'h01, 32'd0, 1'b1);
    wr(6'h0C, 32'h2000_0000, 1'b1);
    wr(6'h0D, {26'd0, 5'd20, 1'b1}, 1'b1);
    wr(6'h0E, 32'h0000_0011, 1'b1);
    wr(6'h1C, 32'h2000_0100, 1'b1);
    wr(6'h1D, {26'd0, 5'd4, 1'b1}, 1'b1);
    wr(6'h1E, 32'h0000_0026, 1'b1);
    look(32'h2000_0110, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    chk({xn, shared, cache_pol, mem_type} == 6'h26, "R8",
        {26'd0, xn, shared, cache_pol, mem_type}, 32'h26);
    look(32'h2000_1000, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    wr(6'h2C, 32'h0, 1'b1);
    wr(6'h2D, {26'd0, 5'd31, 1'b1}, 1'b1);
    wr(6'h2E, 32'h0000_0035, 1'b1);
    look(32'h2000_0110, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    wr(6'h2D, 32'h0, 1'b1);
    wr(6'h1D, {26'd0, 5'd4, 1'b0}, 1'b1);
    look(32'h2000_0110, 1'b1, 1'b1, 1'b1, 1'b1, "R8");

    // R11: zero-region build ignores privileged writes
    rd(6'h3F, 1'b1, "R11");

    // Random phase: R7 R8 R9 R10 R12
    for (int it = 0; it < 600; it++) begin
      int unsigned op;
      op = $urandom_range(0, 9);
      if (op < 6) begin
        logic [5:0] a;
        logic [31:0] d;
        a = {4'($urandom_range(0, 13)), 2'($urandom_range(0, 3))};
        if (op == 0) a = 6'h3F;
        d = $urandom();
        if (a[1:0] == 2'd1 && $urandom_range(0, 2) != 0) d[5:1] = 5'($urandom_range(0, 12));
        wr(a, d, $urandom_range(0, 9) != 0);
      end else begin
        rd(6'($urandom_range(0, 63)), $urandom_range(0, 3) != 0, "R12");
      end
      for (int k = 0; k < 4; k++) begin
        logic [31:0] a;
        int j;
        j = $urandom_range(0, NR - 1);
        a = $urandom();
        if (k < 3) a = {m_base[j], 5'd0} + 32'($urandom_range(0, 80)) - 32'd8;
        if (k == 2) a = {m_base[j], 5'd0} ^ (32'd1 << $urandom_range(0, 12));
        look(a, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
             $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, "R8");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule